// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Manager

This block holds two pending vectors with one bit per processor. One vector holds inter-processor interrupts and the other holds interval-timer interrupts. Software reaches the block through a word-register port. It posts inter-processor interrupts with a processor bitmask, and it clears either kind with a processor bitmask. A separate tick input marks a timer interrupt pending on every processor that is active. Each bit of the two vectors drives a level interrupt output to its processor.

Three kinds of misuse each produce a one-cycle error pulse:
- posting to a processor that is already pending;
- clearing a bit that is not pending;
- issuing an operation whose effective mask is empty.

A packed legacy control word is also decoded. It covers processors 0 to 3 only, and it reports the requester's 2-bit identifier on read. Only processors numbered below the `active_cnt` input take part in any operation.

Top module: `ipi_timer_intc`

## Requirements
- R1: The register index is `reg_addr >> 6`, so the low six address bits are ignored. Writes to an index that is not decoded change no state and flag no error. Reads of such an index return zero.
- R2: A write to index 0x20 sets the inter-processor pending bit of every active processor whose bit is set in `reg_wdata`.
- R3: A write to index 0x21 clears the inter-processor pending bits selected by the mask. A read of index 0x21 returns the inter-processor pending vector.
- R4: A write to index 0x22 clears the timer pending bits selected by the mask. A read of index 0x22 returns the timer pending vector.
- R5: If a post selects a processor whose inter-processor bit is already pending, `err_redundant` pulses one cycle after the write. That bit keeps its state, and the other selected bits are still applied.
- R6: If a clear, of either kind, selects a bit that is not pending, `err_spurious` pulses one cycle after the write. The bits that are pending are still cleared.
- R7: An operation at index 0x20, 0x21 or 0x22 whose mask is zero after active filtering pulses `err_zero`, and neither vector changes.
- R8: A cycle with `tick` high sets the timer pending bit of every active processor.
- R9: If a tick and a timer clear hit the same processor in the same cycle, the bit ends up set.
- R10: A write to the legacy index 0x02 acts on processors 0 to 3 as follows, and all three fields apply in one write:
  - bits 15:12 post inter-processor interrupts;
  - bits 11:8 clear inter-processor interrupts;
  - bits 7:4 clear timer interrupts.
  A legacy write with all three fields zero is not an error.
- R11: A read of the legacy index returns the following fields, with all other bits zero:
  - inter-processor pending bits 3:0 in bits 11:8;
  - timer pending bits 3:0 in bits 7:4;
  - `req_id` in bits 1:0.
- R12: Processors numbered at or above `active_cnt` are ignored by posts, clears and ticks. Mask bits above the active range never raise an error.
- R13: After reset, both pending vectors, all error outputs and `reg_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset within the block |
| reg_wdata | input | DATA_W | Write data or processor mask |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read |
| req_id | input | 2 | Identifier of the requesting processor |
| active_cnt | input | ACT_W | Number of active processors (0 to NPROC) |
| tick | input | 1 | Interval-timer tick |
| ipi_irq | output | NPROC | Inter-processor interrupt level per processor |
| tmr_irq | output | NPROC | Timer interrupt level per processor |
| err_redundant | output | 1 | Post to an already pending processor |
| err_spurious | output | 1 | Clear of a bit that is not pending |
| err_zero | output | 1 | Operation with an empty mask |

## Verification
Every result of this block is registered once. The pending vectors, the interrupt levels and the three error pulses all change on the clock edge that captures a write or a tick. Read data appears on the edge that captures the read. The bench drives each operation half a cycle before an edge and then samples at the falling edge that follows. It drops the strobe at that same point, so each error pulse is observed in exactly the one cycle it is due and is gone before the next operation.

// File: rtl/ipi_intc_pkg.sv
package ipi_intc_pkg;
  localparam int IDX_SHIFT   = 6;
  localparam int IDX_LEGACY  = 'h02;
  localparam int IDX_REQ     = 'h20;
  localparam int IDX_CLR_IPI = 'h21;
  localparam int IDX_CLR_TMR = 'h22;

  typedef struct packed {
    logic zero_mask;
    logic spurious;
    logic redundant;
  } err_t;
endpackage

// File: rtl/ipi_op_decode.sv
module ipi_op_decode
  import ipi_intc_pkg::*;
#(
  parameter int NPROC  = 64,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 64,
  localparam int ACT_W = $clog2(NPROC + 1)
) (
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ACT_W-1:0]  active_cnt,
  input  logic [NPROC-1:0]  ipi_q,
  input  logic [NPROC-1:0]  tmr_q,
  output logic [NPROC-1:0]  act_m,
  output logic [NPROC-1:0]  req_m,
  output logic [NPROC-1:0]  clr_ipi_m,
  output logic [NPROC-1:0]  clr_tmr_m,
  output err_t              err
);
  logic [NPROC-1:0] raw_m;
  logic [NPROC-1:0] leg_req, leg_ci, leg_ct;
  logic             zero_chk;

  for (genvar i = 0; i < NPROC; i++) begin : g_act
    assign act_m[i] = (ACT_W'(i) < active_cnt);
  end

  always_comb begin
    raw_m   = wdata[NPROC-1:0] & act_m;
    leg_req = '0;
    leg_ci  = '0;
    leg_ct  = '0;
    leg_req[3:0] = wdata[15:12];
    leg_ci[3:0]  = wdata[11:8];
    leg_ct[3:0]  = wdata[7:4];
    req_m     = '0;
    clr_ipi_m = '0;
    clr_tmr_m = '0;
    zero_chk  = 1'b0;
    if (wr) begin
      case (idx)
        IDX_W'(IDX_REQ):     begin req_m     = raw_m; zero_chk = 1'b1; end
        IDX_W'(IDX_CLR_IPI): begin clr_ipi_m = raw_m; zero_chk = 1'b1; end
        IDX_W'(IDX_CLR_TMR): begin clr_tmr_m = raw_m; zero_chk = 1'b1; end
        IDX_W'(IDX_LEGACY): begin
          req_m     = leg_req & act_m;
          clr_ipi_m = leg_ci & act_m;
          clr_tmr_m = leg_ct & act_m;
        end
        default: ;
      endcase
    end
    err.zero_mask = zero_chk && (raw_m == '0);
    err.redundant = |(req_m & ipi_q);
    err.spurious  = (|(clr_ipi_m & ~ipi_q)) | (|(clr_tmr_m & ~tmr_q));
  end
endmodule

// File: rtl/ipi_pend_vec.sv
module ipi_pend_vec #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic nxt, en;
    always_comb begin
      en  = set_m[i] | clr_m[i];
      nxt = set_m[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (en) q[i] <= nxt;
    end
  end
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
  import ipi_intc_pkg::*;
#(
  parameter int NPROC  = 64,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  localparam int ACT_W = $clog2(NPROC + 1),
  localparam int IDX_W = ADDR_W - IDX_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        req_id,
  input  logic [ACT_W-1:0]  active_cnt,
  input  logic              tick,
  output logic [NPROC-1:0]  ipi_irq,
  output logic [NPROC-1:0]  tmr_irq,
  output logic              err_redundant,
  output logic              err_spurious,
  output logic              err_zero
);
  logic [IDX_W-1:0]  idx;
  logic              wr, rd;
  logic [NPROC-1:0]  act_m, req_m, clr_ipi_m, clr_tmr_m, tick_m;
  err_t              err_n, err_q;
  logic [DATA_W-1:0] rd_n;
  logic              unused_addr_lo;

  assign idx            = reg_addr[ADDR_W-1:IDX_SHIFT];
  assign unused_addr_lo = ^reg_addr[IDX_SHIFT-1:0];
  assign wr             = reg_en & reg_we;
  assign rd             = reg_en & ~reg_we;

  ipi_op_decode #(.NPROC(NPROC), .IDX_W(IDX_W), .DATA_W(DATA_W)) dec_i (
    .wr(wr), .idx(idx), .wdata(reg_wdata), .active_cnt(active_cnt),
    .ipi_q(ipi_irq), .tmr_q(tmr_irq), .act_m(act_m), .req_m(req_m),
    .clr_ipi_m(clr_ipi_m), .clr_tmr_m(clr_tmr_m), .err(err_n)
  );

  assign tick_m = tick ? act_m : '0;

  ipi_pend_vec #(.W(NPROC)) ipi_vec_i (
    .clk(clk), .rst_n(rst_n), .set_m(req_m), .clr_m(clr_ipi_m), .q(ipi_irq)
  );

  // set dominates clear inside the cell, so a tick beats a timer clear
  ipi_pend_vec #(.W(NPROC)) tmr_vec_i (
    .clk(clk), .rst_n(rst_n), .set_m(tick_m), .clr_m(clr_tmr_m), .q(tmr_irq)
  );

  always_comb begin
    rd_n = '0;
    case (idx)
      IDX_W'(IDX_CLR_IPI): rd_n = DATA_W'(ipi_irq);
      IDX_W'(IDX_CLR_TMR): rd_n = DATA_W'(tmr_irq);
      IDX_W'(IDX_LEGACY): begin
        rd_n[11:8] = ipi_irq[3:0];
        rd_n[7:4]  = tmr_irq[3:0];
        rd_n[1:0]  = req_id;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  reg_rdata <= '0;
    else if (rd) reg_rdata <= rd_n;
  end

  assign err_redundant = err_q.redundant;
  assign err_spurious  = err_q.spurious;
  assign err_zero      = err_q.zero_mask;
endmodule

// File: rtl/ipi_timer_intc_chk.sv
module ipi_timer_intc_chk
  import ipi_intc_pkg::*;
#(
  parameter int NPROC  = 64,
  parameter int ADDR_W = 12,
  localparam int ACT_W = $clog2(NPROC + 1),
  localparam int IDX_W = ADDR_W - IDX_SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [ACT_W-1:0]  active_cnt,
  input logic              tick,
  input logic [NPROC-1:0]  ipi_irq,
  input logic [NPROC-1:0]  tmr_irq,
  input logic              err_redundant,
  input logic              err_zero
);
  logic [IDX_W-1:0] c_idx;
  logic             post_wr, any_wr;
  logic [NPROC-1:0] c_act;

  assign c_idx   = reg_addr[ADDR_W-1:IDX_SHIFT];
  assign any_wr  = reg_en && reg_we;
  assign post_wr = any_wr && (c_idx == IDX_W'(IDX_REQ) || c_idx == IDX_W'(IDX_LEGACY));
  for (genvar i = 0; i < NPROC; i++) begin : g_a
    assign c_act[i] = (ACT_W'(i) < active_cnt);
  end

  // R2
  ipi_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ipi_irq & ~$past(ipi_irq))) |-> $past(post_wr));

  // R8
  tick_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((tmr_irq | ~$past(c_act)) == '1));

  // R7
  zero_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero |-> $stable(ipi_irq));

  // R5
  redundant_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_redundant |-> $past(post_wr));

  // R1
  idle_ipi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(any_wr) |-> $stable(ipi_irq));
endmodule

bind ipi_timer_intc ipi_timer_intc_chk #(.NPROC(NPROC), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .active_cnt(active_cnt), .tick(tick),
  .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .err_redundant(err_redundant),
  .err_zero(err_zero)
);

// File: tb/ipi_timer_intc_tb_top.sv
`timescale 1ns/1ps
module ipi_timer_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_en, reg_we, tick;
  logic [11:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata, ipi_irq, tmr_irq;
  logic [1:0]  req_id;
  logic [6:0]  active_cnt;
  logic        err_redundant, err_spurious, err_zero;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipi_timer_intc dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_id(req_id), .active_cnt(active_cnt), .tick(tick),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .err_redundant(err_redundant),
    .err_spurious(err_spurious), .err_zero(err_zero)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  idx;
    logic [63:0] wd;
    logic        tk;
    logic [63:0] e_ipi;
    logic [63:0] e_tmr;
    logic [2:0]  e_err;  // {zero, spurious, redundant}
  } vec_t;

  localparam logic [63:0] ONES = '1;
  localparam vec_t VECS [11] = '{
    '{1'b1, 6'h20, 64'h5, 1'b0, 64'h5, 64'h0, 3'b000},                                 // R2
    '{1'b1, 6'h20, 64'h6, 1'b0, 64'h7, 64'h0, 3'b001},                                 // R5
    '{1'b1, 6'h21, 64'h9, 1'b0, 64'h6, 64'h0, 3'b010},                                 // R3 R6
    '{1'b0, 6'h05, 64'h0, 1'b1, 64'h6, ONES,  3'b000},                                 // R8
    '{1'b1, 6'h22, 64'hF0, 1'b0, 64'h6, ~64'hF0, 3'b000},                              // R4
    '{1'b1, 6'h20, 64'h0, 1'b0, 64'h6, ~64'hF0, 3'b100},                               // R7
    '{1'b1, 6'h20, 64'h8000_0000_0000_0000, 1'b0, 64'h8000_0000_0000_0006, ~64'hF0, 3'b000}, // R2
    '{1'b1, 6'h21, 64'h8000_0000_0000_0006, 1'b0, 64'h0, ~64'hF0, 3'b000},             // R3
    '{1'b1, 6'h22, 64'h0, 1'b0, 64'h0, ~64'hF0, 3'b100},                               // R7
    '{1'b1, 6'h05, 64'hFFFF, 1'b0, 64'h0, ~64'hF0, 3'b000},                            // R1
    '{1'b1, 6'h22, 64'hF0, 1'b0, 64'h0, ~64'hF0, 3'b010}                               // R6
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; results checked at the next falling edge
  task automatic op(input logic we, input logic [5:0] idx, input logic [63:0] wd, input logic tk);
    reg_en    = we;
    reg_we    = we;
    reg_addr  = {idx, 6'h2A};
    reg_wdata = wd;
    tick      = tk;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [5:0] idx);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = {idx, 6'h00};
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  function automatic logic [63:0] errv();
    return {61'b0, err_zero, err_spurious, err_redundant};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_en = 0; reg_we = 0; tick = 0; reg_addr = '0;
    reg_wdata = '0; req_id = 2'd0; active_cnt = 7'd64;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 ipi", ipi_irq, 64'h0);
    chk("R13 tmr", tmr_irq, 64'h0);
    chk("R13 err", errv(), 64'h0);
    chk("R13 rdata", reg_rdata, 64'h0);

    foreach (VECS[k]) begin
      op(VECS[k].we, VECS[k].idx, VECS[k].wd, VECS[k].tk);
      chk($sformatf("R1-table vec%0d ipi", k), ipi_irq, VECS[k].e_ipi);
      chk($sformatf("vec%0d tmr", k), tmr_irq, VECS[k].e_tmr);
      chk($sformatf("vec%0d err", k), errv(), {61'b0, VECS[k].e_err});
    end

    rd(6'h22); chk("R4 read tmr", reg_rdata, ~64'hF0);
    rd(6'h21); chk("R3 read ipi", reg_rdata, 64'h0);
    rd(6'h05); chk("R1 read unmapped", reg_rdata, 64'h0);

    op(1'b1, 6'h22, 64'h1, 1'b1);
    chk("R9 tick wins", tmr_irq, ONES);
    chk("R9 err", errv(), 64'h0);

    op(1'b1, 6'h02, 64'h3000, 1'b0);
    chk("R10 legacy post", ipi_irq, 64'h3);
    req_id = 2'd2;
    rd(6'h02); chk("R11 legacy read", reg_rdata, 64'h3F2);
    op(1'b1, 6'h02, 64'h0110, 1'b0);
    chk("R10 legacy clear ipi", ipi_irq, 64'h2);
    chk("R10 legacy clear tmr", tmr_irq, ~64'h1);
    op(1'b1, 6'h02, 64'h0, 1'b0);
    chk("R10 legacy empty err", errv(), 64'h0);
    chk("R10 legacy empty ipi", ipi_irq, 64'h2);
    op(1'b1, 6'h02, 64'h3000, 1'b0);
    chk("R5 legacy redundant ipi", ipi_irq, 64'h3);
    chk("R5 legacy redundant err", errv(), 64'h1);

    op(1'b1, 6'h22, ONES, 1'b0);
    chk("R6 clear all tmr", tmr_irq, 64'h0);
    chk("R6 clear all err", errv(), 64'h2);

    active_cnt = 7'd4;
    op(1'b0, 6'h05, 64'h0, 1'b1);
    chk("R12 tick limited", tmr_irq, 64'hF);
    op(1'b1, 6'h20, 64'h30, 1'b0);
    chk("R12 inactive post err", errv(), 64'h4);
    chk("R12 inactive post ipi", ipi_irq, 64'h3);
    op(1'b1, 6'h20, 64'h11, 1'b0);
    chk("R12 partial post ipi", ipi_irq, 64'h3);
    chk("R12 partial post err", errv(), 64'h1);
    op(1'b1, 6'h21, 64'h12, 1'b0);
    chk("R12 clear filtered ipi", ipi_irq, 64'h1);
    chk("R12 clear filtered err", errv(), 64'h0);
    active_cnt = 7'd0;
    op(1'b1, 6'h22, 64'hF, 1'b1);
    chk("R12 none active tmr", tmr_irq, 64'hF);
    chk("R12 none active err", errv(), 64'h4);

    finish_run();
  end
endmodule